// File: doc/BRIEF.md
# GPIO pin drive and sense resolver

This block sits behind the registers of a 32-pin general purpose port and turns each pin's settings into what happens electrically at the pin. Each pin has a configuration word, an output bit and an external stimulus made of a valid bit and a level bit. From these the block decides whether the pin's driver is engaged and at what level. It also decides what the input register samples, whether the pin is fighting an outside source, and whether the pin's level-sense condition is met. The sense results of all pins are merged into one detect line.

The drive-mode field models open-drain and open-source behaviour: in some modes the driver only engages for one output polarity. A pin that nobody drives but that has a pull resistor is treated as driven to the pull level, both on its drive outputs and in its input bit. The input word and the detect line are registered, as is the last drive state of every pin. A per-pin change strobe reports when a pin's drive state differs from the state held at the last clock edge.

Top module: `gpio_pin_resolver`

## Requirements
- R1: The drive field (configuration bits 10:8) engages the driver always for values 0 to 3, only when the output bit is 1 for values 4 and 5, and only when the output bit is 0 for values 6 and 7. It engages only if direction bit 0 is 1. An engaged driver gives drvEn=1 and drvLevel equal to the output bit.
- R2: With input-disconnect bit 1 set, the pull field (bits 3:2, 1 = pull-down, 3 = pull-up, 0 and 2 = none) sets the pin's input bit to the pull level one clock later. Without a pull the stimulus level is taken when valid, otherwise the bit holds.
- R3: With bit 1 clear, no valid stimulus, the driver not engaged and a pull active, the pin reports drvEn=1 with drvLevel equal to the pull level, and the input bit takes that level one clock later.
- R4: With bit 1 clear, no valid stimulus and the driver engaged, the input bit takes the drive level one clock later.
- R5: With bit 1 clear and a valid stimulus, the input bit takes the stimulus level one clock later.
- R6: A pin with no valid stimulus, no engaged driver and no pull keeps its input bit unchanged, whatever the stimulus level does.
- R7: shortFlag for a pin is 1, in the same cycle, exactly when bit 1 is clear, the stimulus is valid, the driver is engaged and the output bit differs from the stimulus level.
- R8: The sense field (bits 17:16) matches a valid stimulus at level 1 for value 2 and at level 0 for value 3, only with bit 1 clear. Values 0 and 1 never match. detect is the OR of all pin matches, registered one clock later.
- R9: drvChange for a pin is 1 exactly while its current drvEn or drvLevel differs from the value held at the previous clock edge.
- R10: Reset clears the input word, detect and the held drive state of every pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWords | input | NUM_PINS*CFG_W | Configuration words, pin i in bits i*CFG_W upward |
| outWord | input | NUM_PINS | Output register bits |
| extValid | input | NUM_PINS | External stimulus present per pin |
| extLevel | input | NUM_PINS | External stimulus level per pin |
| inWord | output | NUM_PINS | Resolved input register value |
| drvEn | output | NUM_PINS | Driver engaged per pin |
| drvLevel | output | NUM_PINS | Level presented by the pin driver |
| drvChange | output | NUM_PINS | Drive state differs from last clock edge |
| shortFlag | output | NUM_PINS | Pin driven both internally and externally at different levels |
| detect | output | 1 | OR of all pin sense matches |

## Verification
The resolver is tried with one pin configured at a time while every other pin stays disconnected without pull. This isolates the pin under test and shows that no other pin drives, shorts or raises detect. Drive-mode patterns pair each mode group with both output polarities, which separates always-on, open-drain and open-source engagement. Pull, stimulus and buffer-disconnect combinations show which source wins the input bit: pull over stimulus when disconnected, stimulus over driver when connected, and the hold case when there is no source at all. Sense values are paired with both stimulus levels and with a disconnected buffer, and a directed step on one pin's drive shows that the change strobe lasts exactly one cycle.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  // Configuration word field positions
  localparam int DIR_BIT   = 0;
  localparam int DISC_BIT  = 1;
  localparam int PULL_LSB  = 2;
  localparam int DRV_LSB   = 8;
  localparam int SENSE_LSB = 16;
  localparam int MIN_CFG_W = SENSE_LSB + 2;

  localparam logic [1:0] PULL_DOWN  = 2'd1;
  localparam logic [1:0] PULL_UP    = 2'd3;
  localparam logic [1:0] SENSE_HIGH = 2'd2;
  localparam logic [1:0] SENSE_LOW  = 2'd3;

  // Per-pin strobes from the decode stage to the datapath
  typedef struct packed {
    logic drvOk;    // driver engaged by mode and direction
    logic bufOn;    // input buffer connected
    logic pullOn;   // a pull resistor is active
    logic pullLvl;  // level of that pull
    logic senseHi;  // sense on level 1
    logic senseLo;  // sense on level 0
  } pin_strobe_t;
endpackage

// File: rtl/gpio_res_ctrl.sv
module gpio_res_ctrl
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CFG_W    = 32
) (
  input  logic [NUM_PINS*CFG_W-1:0]     cfgWords,
  input  logic [NUM_PINS-1:0]           outWord,
  output pin_strobe_t [NUM_PINS-1:0]    strobes
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CFG_W-1:0] cfg;
    logic [2:0]       drvMode;
    logic [1:0]       pullSel;
    logic [1:0]       senseSel;
    logic             modeOk;

    assign cfg      = cfgWords[p*CFG_W +: CFG_W];
    assign drvMode  = cfg[DRV_LSB +: 3];
    assign pullSel  = cfg[PULL_LSB +: 2];
    assign senseSel = cfg[SENSE_LSB +: 2];

    always_comb begin
      if (!drvMode[2])        modeOk = 1'b1;          // push-pull group
      else if (!drvMode[1])   modeOk = outWord[p];    // drives high only
      else                    modeOk = !outWord[p];   // drives low only
    end

    assign strobes[p].drvOk   = modeOk && cfg[DIR_BIT];
    assign strobes[p].bufOn   = !cfg[DISC_BIT];
    assign strobes[p].pullOn  = (pullSel == PULL_DOWN) || (pullSel == PULL_UP);
    assign strobes[p].pullLvl = (pullSel == PULL_UP);
    assign strobes[p].senseHi = (senseSel == SENSE_HIGH);
    assign strobes[p].senseLo = (senseSel == SENSE_LOW);
  end
endmodule

// File: rtl/gpio_res_dp.sv
module gpio_res_dp
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pin_strobe_t [NUM_PINS-1:0]  strobes,
  input  logic [NUM_PINS-1:0]         outWord,
  input  logic [NUM_PINS-1:0]         extValid,
  input  logic [NUM_PINS-1:0]         extLevel,
  output logic [NUM_PINS-1:0]         inWord,
  output logic [NUM_PINS-1:0]         drvEn,
  output logic [NUM_PINS-1:0]         drvLevel,
  output logic [NUM_PINS-1:0]         drvChange,
  output logic [NUM_PINS-1:0]         shortFlag,
  output logic                        detect
);
  logic [NUM_PINS-1:0] inNext;
  logic [NUM_PINS-1:0] senseHit;
  logic [NUM_PINS-1:0] prevEn;
  logic [NUM_PINS-1:0] prevLvl;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pin_strobe_t s;
      logic floatDrive;
      s          = strobes[p];
      floatDrive = s.bufOn && !extValid[p] && !s.drvOk && s.pullOn;

      drvEn[p]    = s.drvOk || floatDrive;
      drvLevel[p] = floatDrive ? s.pullLvl : outWord[p];

      if (!s.bufOn) begin
        if (s.pullOn)          inNext[p] = s.pullLvl;
        else if (extValid[p])  inNext[p] = extLevel[p];
        else                   inNext[p] = inWord[p];
      end else if (extValid[p]) begin
        inNext[p] = extLevel[p];
      end else if (drvEn[p]) begin
        inNext[p] = drvLevel[p];
      end else begin
        inNext[p] = inWord[p];
      end

      shortFlag[p] = s.bufOn && extValid[p] && s.drvOk && (outWord[p] != extLevel[p]);
      senseHit[p]  = s.bufOn && extValid[p] &&
                     ((s.senseHi && extLevel[p]) || (s.senseLo && !extLevel[p]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inWord  <= '0;
      detect  <= 1'b0;
      prevEn  <= '0;
      prevLvl <= '0;
    end else begin
      inWord  <= inNext;
      detect  <= |senseHit;
      prevEn  <= drvEn;
      prevLvl <= drvLevel;
    end
  end

  assign drvChange = (drvEn ^ prevEn) | (drvLevel ^ prevLvl);
endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CFG_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PINS*CFG_W-1:0]   cfgWords,
  input  logic [NUM_PINS-1:0]         outWord,
  input  logic [NUM_PINS-1:0]         extValid,
  input  logic [NUM_PINS-1:0]         extLevel,
  output logic [NUM_PINS-1:0]         inWord,
  output logic [NUM_PINS-1:0]         drvEn,
  output logic [NUM_PINS-1:0]         drvLevel,
  output logic [NUM_PINS-1:0]         drvChange,
  output logic [NUM_PINS-1:0]         shortFlag,
  output logic                        detect
);
  pin_strobe_t [NUM_PINS-1:0] strobes;

  gpio_res_ctrl #(.NUM_PINS(NUM_PINS), .CFG_W(CFG_W)) u_ctrl (
    .cfgWords (cfgWords),
    .outWord  (outWord),
    .strobes  (strobes)
  );

  gpio_res_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .outWord   (outWord),
    .extValid  (extValid),
    .extLevel  (extLevel),
    .inWord    (inWord),
    .drvEn     (drvEn),
    .drvLevel  (drvLevel),
    .drvChange (drvChange),
    .shortFlag (shortFlag),
    .detect    (detect)
  );
endmodule

// File: rtl/gpio_pin_resolver_chk.sv
module gpio_pin_resolver_chk
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CFG_W    = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PINS*CFG_W-1:0]   cfgWords,
  input logic [NUM_PINS-1:0]         extValid,
  input logic [NUM_PINS-1:0]         extLevel,
  input logic [NUM_PINS-1:0]         inWord,
  input logic [NUM_PINS-1:0]         drvEn,
  input logic [NUM_PINS-1:0]         drvLevel,
  input logic [NUM_PINS-1:0]         drvChange,
  input logic [NUM_PINS-1:0]         shortFlag,
  input logic                        detect
);
  logic [NUM_PINS-1:0] bufMask;
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
    assign bufMask[p] = !cfgWords[p*CFG_W + DISC_BIT];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (inWord == '0 && !detect)); // R10

  AST_EXT_SAMPLED: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (((inWord ^ $past(extLevel)) & $past(extValid & bufMask)) == '0)); // R5

  AST_SHORT_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rstN)
    ((shortFlag & ~(extValid & bufMask)) == '0)); // R7

  AST_DETECT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (detect && $past(rstN)) |-> $past(|(extValid & bufMask))); // R8

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && drvChange == '0) |-> ($stable(drvEn) && $stable(drvLevel))); // R9
endmodule

bind gpio_pin_resolver gpio_pin_resolver_chk #(.NUM_PINS(NUM_PINS), .CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWords  (cfgWords),
  .extValid  (extValid),
  .extLevel  (extLevel),
  .inWord    (inWord),
  .drvEn     (drvEn),
  .drvLevel  (drvLevel),
  .drvChange (drvChange),
  .shortFlag (shortFlag),
  .detect    (detect)
);

// File: tb/gpio_pin_resolver_bench.sv
module gpio_pin_resolver_bench;
  localparam int NP = 32;
  localparam int CW = 32;
  localparam logic [CW-1:0] IDLE_CFG = 32'h2; // input disconnected, no pull, dir 0

  typedef struct packed {
    logic [4:0] pin;
    logic       dir, disc;
    logic [1:0] pull;
    logic [2:0] drv;
    logic [1:0] sense;
    logic       out, ev, el;
    logic       expEn, expLvl, expSh, expIn, expDet;
  } vec_t;

  function automatic vec_t mk(int pin, int dir, int disc, int pull, int drv, int sense,
                              int out, int ev, int el,
                              int en, int lvl, int sh, int in, int det);
    vec_t r;
    r.pin = 5'(pin);   r.dir = 1'(dir);  r.disc = 1'(disc);
    r.pull = 2'(pull); r.drv = 3'(drv);  r.sense = 2'(sense);
    r.out = 1'(out);   r.ev = 1'(ev);    r.el = 1'(el);
    r.expEn = 1'(en);  r.expLvl = 1'(lvl); r.expSh = 1'(sh);
    r.expIn = 1'(in);  r.expDet = 1'(det);
    return r;
  endfunction

  localparam int NV = 20;
  //                 pin dir disc pull drv sns out ev el  en lvl sh in det
  localparam vec_t VECS [NV] = '{
    mk( 0, 1, 0, 0, 0, 0, 1, 0, 0,  1, 1, 0, 1, 0),  // R1 R4 push-pull high
    mk( 3, 1, 0, 0, 4, 0, 1, 0, 0,  1, 1, 0, 1, 0),  // R1 high-only, out 1
    mk( 5, 1, 0, 3, 5, 0, 0, 0, 0,  1, 1, 0, 1, 0),  // R1 R3 high-only released, pull-up
    mk( 7, 1, 0, 1, 6, 0, 0, 0, 0,  1, 0, 0, 0, 0),  // R1 R4 low-only engaged
    mk( 7, 1, 0, 1, 6, 0, 1, 0, 0,  1, 0, 0, 0, 0),  // R3 low-only released, pull-down
    mk( 9, 0, 0, 3, 0, 0, 0, 0, 0,  1, 1, 0, 1, 0),  // R1 dir 0 gates, R3 pull-up floats
    mk(12, 0, 1, 3, 0, 0, 0, 0, 0,  0, 0, 0, 1, 0),  // R2 disconnected pull-up
    mk(12, 0, 1, 1, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0),  // R2 disconnected pull-down
    mk(15, 0, 1, 0, 0, 0, 0, 1, 1,  0, 0, 0, 1, 0),  // R2 disconnected, no pull, stimulus
    mk(15, 0, 1, 3, 0, 0, 0, 1, 0,  0, 0, 0, 1, 0),  // R2 pull wins over stimulus
    mk(20, 0, 0, 0, 0, 2, 0, 1, 1,  0, 0, 0, 1, 1),  // R5 R8 sense high hit
    mk(20, 0, 0, 0, 0, 2, 0, 1, 0,  0, 0, 0, 0, 0),  // R5 R8 sense high miss
    mk(21, 0, 0, 0, 0, 3, 0, 1, 0,  0, 0, 0, 0, 1),  // R8 sense low hit
    mk(21, 0, 0, 0, 0, 1, 0, 1, 1,  0, 0, 0, 1, 0),  // R8 sense value 1 inert
    mk(25, 1, 0, 0, 0, 0, 1, 1, 0,  1, 1, 1, 0, 0),  // R7 short, R5 stimulus wins input
    mk(25, 1, 0, 0, 0, 0, 1, 1, 1,  1, 1, 0, 1, 0),  // R7 levels agree
    mk(26, 1, 0, 0, 4, 0, 0, 1, 1,  0, 0, 0, 1, 0),  // R7 released driver never shorts
    mk(31, 0, 1, 0, 0, 2, 0, 1, 1,  0, 0, 0, 1, 0),  // R8 disconnected buffer no sense
    mk( 2, 1, 0, 0, 7, 0, 0, 0, 0,  1, 0, 0, 0, 0),  // R1 mode 7 low, R4
    mk(30, 1, 0, 0, 2, 0, 0, 0, 0,  1, 0, 0, 0, 0)   // R1 mode 2 push-pull low
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NP*CW-1:0]  cfgWords;
  logic [NP-1:0]     outWord, extValid, extLevel;
  logic [NP-1:0]     inWord, drvEn, drvLevel, drvChange, shortFlag;
  logic              detect;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_pin_resolver #(.NUM_PINS(NP), .CFG_W(CW)) u_gpio_pin_resolver (
    .clk(clk), .rstN(rstN), .cfgWords(cfgWords), .outWord(outWord),
    .extValid(extValid), .extLevel(extLevel), .inWord(inWord), .drvEn(drvEn),
    .drvLevel(drvLevel), .drvChange(drvChange), .shortFlag(shortFlag), .detect(detect)
  );

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mkCfg(logic dir, logic disc, logic [1:0] pull,
                                          logic [2:0] drv, logic [1:0] sense);
    logic [CW-1:0] c;
    c = '0;
    c[0] = dir; c[1] = disc; c[3:2] = pull; c[10:8] = drv; c[17:16] = sense;
    return c;
  endfunction

  task automatic idleAll();
    for (int p = 0; p < NP; p++) cfgWords[p*CW +: CW] = IDLE_CFG;
    outWord = '0; extValid = '0; extLevel = '0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    idleAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 inWord after reset", inWord, '0);
    chk("R10 detect after reset", NP'(detect), '0);
    chk("R10 drvChange after reset", drvChange, '0);

    // Vector table, one pin active at a time
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      @(negedge clk);
      idleAll();
      cfgWords[t.pin*CW +: CW] = mkCfg(t.dir, t.disc, t.pull, t.drv, t.sense);
      outWord[t.pin]  = t.out;
      extValid[t.pin] = t.ev;
      extLevel[t.pin] = t.el;
      #1;
      chk($sformatf("R1/R3 drvEn vec %0d", v), drvEn, NP'(t.expEn) << t.pin);
      chk($sformatf("R1/R3 drvLevel vec %0d", v), NP'(drvLevel[t.pin]), NP'(t.expLvl));
      chk($sformatf("R7 shortFlag vec %0d", v), shortFlag, NP'(t.expSh) << t.pin);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R4/R5 inWord bit vec %0d", v), NP'(inWord[t.pin]), NP'(t.expIn));
      chk($sformatf("R8 detect vec %0d", v), NP'(detect), NP'(t.expDet));
    end

    // R6: hold with no source, stimulus level ignored while invalid
    @(negedge clk);
    idleAll();
    cfgWords[4*CW +: CW] = mkCfg(1'b0, 1'b0, 2'd0, 3'd0, 2'd0);
    extValid[4] = 1'b1; extLevel[4] = 1'b1;
    @(negedge clk);
    chk("R5 pin4 sampled 1", NP'(inWord[4]), 1);
    extValid[4] = 1'b0; extLevel[4] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 pin4 held 1 after release", NP'(inWord[4]), 1);
    extValid[4] = 1'b1; extLevel[4] = 1'b0;
    @(negedge clk);
    chk("R5 pin4 sampled 0", NP'(inWord[4]), 0);
    extValid[4] = 1'b0; extLevel[4] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 pin4 held 0, level ignored", NP'(inWord[4]), 0);
    cfgWords[4*CW +: CW] = IDLE_CFG;
    repeat (2) @(negedge clk);
    chk("R6 disconnected no pull holds", NP'(inWord[4]), 0);

    // R9: change strobe lasts one cycle
    idleAll();
    repeat (2) @(negedge clk);
    chk("R9 quiet strobe", drvChange, '0);
    cfgWords[2*CW +: CW] = mkCfg(1'b1, 1'b1, 2'd0, 3'd0, 2'd0);
    outWord[2] = 1'b1;
    #1;
    chk("R9 strobe on change", drvChange, NP'(1) << 2);
    @(negedge clk);
    chk("R9 strobe cleared next cycle", drvChange, '0);
    chk("R1 pin2 still driven", drvEn, NP'(1) << 2);
    outWord[2] = 1'b0;
    #1;
    chk("R9 strobe on level change", drvChange, NP'(1) << 2);

    // R10: reset in mid-run clears the input word
    @(negedge clk);
    idleAll();
    cfgWords[8*CW +: CW] = mkCfg(1'b0, 1'b1, 2'd3, 3'd0, 2'd0);
    @(negedge clk);
    chk("R2 pin8 pulled up", NP'(inWord[8]), 1);
    rstN = 1'b0;
    #1;
    chk("R10 inWord cleared by reset", inWord, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 pin8 pulled again after reset", NP'(inWord[8]), 1);

    finish();
  end
endmodule